// File: doc/BRIEF.md
# TLB Translation Fault Classifier

This block is a small, fully associative translation lookaside buffer with one lookup port for instruction fetches and one for data accesses. Each port takes an effective address, a user-mode flag and that port's translation-enable bit. The data port also takes an access type. One cycle later each port returns either a physical address or a fault code. A separate syndrome word marks the single cause behind an error fault. A handler can read that word to decide which recovery path to take.

Misses and errors are kept apart. A miss means that no loaded entry matches the effective page number. An error means that an entry matches but cannot be used. That happens when its segment or page is marked invalid, when the access breaks the protection attributes, when a fetch targets guarded storage, or when a write-like access reaches a page whose change bit is clear. The block never fills an entry by itself. Software loads every translation through a reload port, and a per-side round-robin pointer picks the slot each new entry overwrites.

Top module: `tlb_fault_unit`

## Requirements
- R1: A lookup presented on a port in cycle N gives its response after the next clock edge, with the response-valid output high for exactly that cycle. A cycle with no request yields response-valid 0, fault code 0, syndrome 0 and address 0.
- R2: When a port's translation enable is 0, the returned address equals the effective address and the fault code is 0 (none), whatever the TLB holds.
- R3: With instruction translation on, a fetch whose page number matches no loaded instruction entry reports fault code 1 (instruction miss). The fetch port only ever reports codes 0, 1 or 3.
- R4: With data translation on, an access of any type whose page number matches no loaded data entry reports fault code 2 (data miss). The data port only ever reports codes 0, 2 or 4.
- R5: A matching entry whose segment-valid bit (attribute bit 0) or page-valid bit (attribute bit 1) is 0 causes an error: code 3 on the fetch port or code 4 on the data port, with syndrome bit 0 set.
- R6: A protection violation causes an error with syndrome bit 1. A violation is a user-mode access to an entry whose user-access bit (attribute bit 2) is 0, or a write-like data access to an entry whose write-permit bit (attribute bit 3) is 0.
- R7: A permitted fetch to an entry whose guarded bit (attribute bit 4) is 1 causes an instruction error with syndrome bit 2. The guarded bit has no effect on data accesses.
- R8: Data access types are encoded as 0 load, 1 store, 2 read-like cache operation and 3 write-like cache operation (zeroing or invalidate). Types 1 and 3 are write-like. A permitted write-like access to an entry whose change bit (attribute bit 5) is 0 causes a data error with syndrome bit 3. Types 0 and 2 ignore the change bit.
- R9: Each response carries at most one fault. A miss wins over any error. Among errors the order is invalid, then protection, then guarded (fetch) or change (data). An error response has exactly one syndrome bit set, and every other response has syndrome 0.
- R10: A reload with side 0 writes the instruction TLB and side 1 writes the data TLB. Each side has its own slot pointer, which starts at slot 0 after reset and advances by one per reload of that side, wrapping after the last slot. A reloaded translation is visible to lookups from the following cycle, and a reload never changes the other side.
- R11: A successful translated lookup returns the entry's physical page number joined to the untouched page offset, with fault code 0. Any faulting response returns address 0.
- R12: Reset empties both TLBs, so every translated lookup after reset misses until software reloads entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | Fetch lookup request |
| fetchEa | input | EA_W | Fetch effective address |
| fetchXlateOn | input | 1 | Instruction translation enable |
| fetchUser | input | 1 | Fetch issued in user mode |
| dataValid | input | 1 | Data lookup request |
| dataEa | input | EA_W | Data effective address |
| dataType | input | 2 | Data access type (0 load, 1 store, 2 read-like cache op, 3 write-like cache op) |
| dataXlateOn | input | 1 | Data translation enable |
| dataUser | input | 1 | Data access issued in user mode |
| rldValid | input | 1 | Software reload strobe |
| rldSide | input | 1 | Reload target: 0 instruction, 1 data |
| rldVpn | input | EA_W-PAGE_BITS | Virtual page number of the reloaded entry |
| rldPpn | input | EA_W-PAGE_BITS | Physical page number of the reloaded entry |
| rldAttr | input | 6 | Attributes: bit0 segment valid, bit1 page valid, bit2 user access, bit3 write permit, bit4 guarded, bit5 changed |
| fetchRspValid | output | 1 | Fetch response valid |
| fetchPa | output | EA_W | Fetch physical address |
| fetchFault | output | 3 | Fetch fault code |
| fetchSyndrome | output | 4 | Fetch error cause: bit0 invalid, bit1 protection, bit2 guarded, bit3 change |
| dataRspValid | output | 1 | Data response valid |
| dataPa | output | EA_W | Data physical address |
| dataFault | output | 3 | Data fault code |
| dataSyndrome | output | 4 | Data error cause: bit0 invalid, bit1 protection, bit2 guarded, bit3 change |

## Verification
Lookups are tried with translation off, with an empty TLB, and against entries whose attribute patterns each trip one cause alone. A separation between a miss and an error, or between two error causes, shows up as a different code or syndrome bit. Entries that carry two faulty attributes at once are then looked up, and the syndrome shows whether the priority order between causes is kept. Each data entry is hit with all four access types, which tells the write-like types from the read-like ones for both the protection and the change-bit checks. A run of nine reloads to one side, with lookups to the other side in between, shows that the round-robin slot choice and the split between the two sides both work.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_IMISS = 3'd1,
    FLT_DMISS = 3'd2,
    FLT_IERR  = 3'd3,
    FLT_DERR  = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_LOAD   = 2'd0,
    ACC_STORE  = 2'd1,
    ACC_CMO_RD = 2'd2,
    ACC_CMO_WR = 2'd3
  } dacc_e;

  // Packed from MSB down: bit 0 is segOk, bit 5 is changed.
  typedef struct packed {
    logic changed;
    logic guarded;
    logic writeOk;
    logic userOk;
    logic pageOk;
    logic segOk;
  } attr_t;

  localparam int ATTR_W      = 6;
  localparam int SYN_W       = 4;
  localparam int SYN_INVALID = 0;
  localparam int SYN_PROT    = 1;
  localparam int SYN_GUARD   = 2;
  localparam int SYN_CHANGE  = 3;

  typedef struct packed {
    logic wrInstr;
    logic wrData;
    logic dWriteLike;
  } tlbf_strobe_t;

endpackage

// File: rtl/tlbf_port.sv
module tlbf_port import tlbf_pkg::*; #(
  parameter int EA_W = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES = 8,
  parameter bit IS_DATA = 1'b0,
  localparam int VPN_W = EA_W - PAGE_BITS,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [VPN_W-1:0] wrPpn,
  input  attr_t            wrAttr,
  input  logic             reqValid,
  input  logic [EA_W-1:0]  reqEa,
  input  logic             xlateOn,
  input  logic             userMode,
  input  logic             writeLike,
  output logic             rspValid,
  output logic [EA_W-1:0]  rspPa,
  output fault_e           rspFault,
  output logic [SYN_W-1:0] rspSyn
);

  localparam fault_e MISS_CODE = IS_DATA ? FLT_DMISS : FLT_IMISS;
  localparam fault_e ERR_CODE  = IS_DATA ? FLT_DERR  : FLT_IERR;

  logic [ENTRIES-1:0] present;
  logic [ENTRIES-1:0] matchVec;
  logic [VPN_W-1:0]   vpnArr [ENTRIES];
  logic [VPN_W-1:0]   ppnArr [ENTRIES];
  attr_t              attrArr [ENTRIES];

  logic [VPN_W-1:0]   reqVpn;
  logic [IDX_W-1:0]   selIdx;
  attr_t              selAttr;
  logic [VPN_W-1:0]   selPpn;

  fault_e             nxtFault;
  logic [SYN_W-1:0]   nxtSyn;
  logic [EA_W-1:0]    nxtPa;

  assign reqVpn = reqEa[EA_W-1:PAGE_BITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     present <= '0;
    else if (wrEn) present[wrIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      vpnArr[wrIdx]  <= wrVpn;
      ppnArr[wrIdx]  <= wrPpn;
      attrArr[wrIdx] <= wrAttr;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign matchVec[i] = present[i] && (vpnArr[i] == reqVpn);
  end

  // Lowest matching slot wins if software loaded duplicates.
  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign selAttr = attrArr[selIdx];
  assign selPpn  = ppnArr[selIdx];

  always_comb begin
    nxtFault = FLT_NONE;
    nxtSyn   = '0;
    nxtPa    = '0;
    if (!reqValid) begin
      nxtFault = FLT_NONE;
    end else if (!xlateOn) begin
      nxtPa = reqEa;
    end else if (matchVec == '0) begin
      nxtFault = MISS_CODE;
    end else if (!selAttr.segOk || !selAttr.pageOk) begin
      nxtFault = ERR_CODE;
      nxtSyn[SYN_INVALID] = 1'b1;
    end else if ((userMode && !selAttr.userOk) || (writeLike && !selAttr.writeOk)) begin
      nxtFault = ERR_CODE;
      nxtSyn[SYN_PROT] = 1'b1;
    end else if (!IS_DATA && selAttr.guarded) begin
      nxtFault = ERR_CODE;
      nxtSyn[SYN_GUARD] = 1'b1;
    end else if (IS_DATA && writeLike && !selAttr.changed) begin
      nxtFault = ERR_CODE;
      nxtSyn[SYN_CHANGE] = 1'b1;
    end else begin
      nxtPa = {selPpn, reqEa[PAGE_BITS-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspPa    <= '0;
      rspFault <= FLT_NONE;
      rspSyn   <= '0;
    end else begin
      rspValid <= reqValid;
      rspPa    <= nxtPa;
      rspFault <= nxtFault;
      rspSyn   <= nxtSyn;
    end
  end

endmodule

// File: rtl/tlbf_control.sv
module tlbf_control import tlbf_pkg::*; #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rldValid,
  input  logic             rldSide,
  input  logic [1:0]       dataType,
  output tlbf_strobe_t     strobe,
  output logic [IDX_W-1:0] iSlot,
  output logic [IDX_W-1:0] dSlot
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(ENTRIES - 1);

  function automatic logic [IDX_W-1:0] nextSlot(input logic [IDX_W-1:0] cur);
    return (cur == LAST_SLOT) ? '0 : cur + 1'b1;
  endfunction

  dacc_e accType;
  assign accType = dacc_e'(dataType);

  always_comb begin
    strobe.wrInstr    = rldValid && !rldSide;
    strobe.wrData     = rldValid && rldSide;
    strobe.dWriteLike = (accType == ACC_STORE) || (accType == ACC_CMO_WR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iSlot <= '0;
      dSlot <= '0;
    end else begin
      if (strobe.wrInstr) iSlot <= nextSlot(iSlot);
      if (strobe.wrData)  dSlot <= nextSlot(dSlot);
    end
  end

endmodule

// File: rtl/tlbf_datapath.sv
module tlbf_datapath import tlbf_pkg::*; #(
  parameter int EA_W = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES = 8,
  localparam int VPN_W = EA_W - PAGE_BITS,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbf_strobe_t      strobe,
  input  logic [IDX_W-1:0]  iSlot,
  input  logic [IDX_W-1:0]  dSlot,
  input  logic [VPN_W-1:0]  rldVpn,
  input  logic [VPN_W-1:0]  rldPpn,
  input  logic [ATTR_W-1:0] rldAttr,
  input  logic              fetchValid,
  input  logic [EA_W-1:0]   fetchEa,
  input  logic              fetchXlateOn,
  input  logic              fetchUser,
  input  logic              dataValid,
  input  logic [EA_W-1:0]   dataEa,
  input  logic              dataXlateOn,
  input  logic              dataUser,
  output logic              fetchRspValid,
  output logic [EA_W-1:0]   fetchPa,
  output fault_e            fetchFault,
  output logic [SYN_W-1:0]  fetchSyndrome,
  output logic              dataRspValid,
  output logic [EA_W-1:0]   dataPa,
  output fault_e            dataFault,
  output logic [SYN_W-1:0]  dataSyndrome
);

  attr_t newAttr;
  assign newAttr = attr_t'(rldAttr);

  tlbf_port #(.EA_W(EA_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES), .IS_DATA(1'b0)) u_fetchTlb (
    .clk(clk), .rstN(rstN),
    .wrEn(strobe.wrInstr), .wrIdx(iSlot), .wrVpn(rldVpn), .wrPpn(rldPpn), .wrAttr(newAttr),
    .reqValid(fetchValid), .reqEa(fetchEa), .xlateOn(fetchXlateOn),
    .userMode(fetchUser), .writeLike(1'b0),
    .rspValid(fetchRspValid), .rspPa(fetchPa), .rspFault(fetchFault), .rspSyn(fetchSyndrome)
  );

  tlbf_port #(.EA_W(EA_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES), .IS_DATA(1'b1)) u_dataTlb (
    .clk(clk), .rstN(rstN),
    .wrEn(strobe.wrData), .wrIdx(dSlot), .wrVpn(rldVpn), .wrPpn(rldPpn), .wrAttr(newAttr),
    .reqValid(dataValid), .reqEa(dataEa), .xlateOn(dataXlateOn),
    .userMode(dataUser), .writeLike(strobe.dWriteLike),
    .rspValid(dataRspValid), .rspPa(dataPa), .rspFault(dataFault), .rspSyn(dataSyndrome)
  );

endmodule

// File: rtl/tlb_fault_unit.sv
module tlb_fault_unit import tlbf_pkg::*; #(
  parameter int EA_W = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES = 8,
  localparam int VPN_W = EA_W - PAGE_BITS,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic [EA_W-1:0]  fetchEa,
  input  logic             fetchXlateOn,
  input  logic             fetchUser,
  input  logic             dataValid,
  input  logic [EA_W-1:0]  dataEa,
  input  logic [1:0]       dataType,
  input  logic             dataXlateOn,
  input  logic             dataUser,
  input  logic             rldValid,
  input  logic             rldSide,
  input  logic [VPN_W-1:0] rldVpn,
  input  logic [VPN_W-1:0] rldPpn,
  input  logic [5:0]       rldAttr,
  output logic             fetchRspValid,
  output logic [EA_W-1:0]  fetchPa,
  output logic [2:0]       fetchFault,
  output logic [3:0]       fetchSyndrome,
  output logic             dataRspValid,
  output logic [EA_W-1:0]  dataPa,
  output logic [2:0]       dataFault,
  output logic [3:0]       dataSyndrome
);

  tlbf_strobe_t     strobe;
  logic [IDX_W-1:0] iSlot;
  logic [IDX_W-1:0] dSlot;
  fault_e           fetchFaultE;
  fault_e           dataFaultE;

  tlbf_control #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rldValid(rldValid), .rldSide(rldSide),
    .dataType(dataType), .strobe(strobe), .iSlot(iSlot), .dSlot(dSlot)
  );

  tlbf_datapath #(.EA_W(EA_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .iSlot(iSlot), .dSlot(dSlot),
    .rldVpn(rldVpn), .rldPpn(rldPpn), .rldAttr(rldAttr),
    .fetchValid(fetchValid), .fetchEa(fetchEa), .fetchXlateOn(fetchXlateOn), .fetchUser(fetchUser),
    .dataValid(dataValid), .dataEa(dataEa), .dataXlateOn(dataXlateOn), .dataUser(dataUser),
    .fetchRspValid(fetchRspValid), .fetchPa(fetchPa), .fetchFault(fetchFaultE), .fetchSyndrome(fetchSyndrome),
    .dataRspValid(dataRspValid), .dataPa(dataPa), .dataFault(dataFaultE), .dataSyndrome(dataSyndrome)
  );

  assign fetchFault = fetchFaultE;
  assign dataFault  = dataFaultE;

endmodule

// File: rtl/tlbf_checker.sv
module tlbf_checker #(
  parameter int EA_W = 32,
  parameter int PAGE_BITS = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            fetchValid,
  input logic [EA_W-1:0] fetchEa,
  input logic            fetchXlateOn,
  input logic            dataValid,
  input logic [EA_W-1:0] dataEa,
  input logic [1:0]      dataType,
  input logic            dataXlateOn,
  input logic            fetchRspValid,
  input logic [EA_W-1:0] fetchPa,
  input logic [2:0]      fetchFault,
  input logic [3:0]      fetchSyndrome,
  input logic            dataRspValid,
  input logic [EA_W-1:0] dataPa,
  input logic [2:0]      dataFault,
  input logic [3:0]      dataSyndrome
);

  assert_fetch_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> (!fetchRspValid && fetchFault == 3'd0 && fetchSyndrome == 4'd0));
  assert_data_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |=> (!dataRspValid && dataFault == 3'd0 && dataSyndrome == 4'd0));

  assert_fetch_passthru_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchXlateOn) |=> (fetchFault == 3'd0 && fetchPa == $past(fetchEa)));
  assert_data_passthru_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !dataXlateOn) |=> (dataFault == 3'd0 && dataPa == $past(dataEa)));

  assert_fetch_codes_R3: assert property (@(posedge clk) disable iff (!rstN)
    fetchFault == 3'd0 || fetchFault == 3'd1 || fetchFault == 3'd3);
  assert_data_codes_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataFault == 3'd0 || dataFault == 3'd2 || dataFault == 3'd4);

  assert_data_no_guard_R7: assert property (@(posedge clk) disable iff (!rstN)
    !dataSyndrome[2]);

  assert_read_no_change_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !dataType[0]) |=> !dataSyndrome[3]);

  assert_fetch_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fetchFault == 3'd3) |-> ($countones(fetchSyndrome) == 1));
  assert_data_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dataFault == 3'd4) |-> ($countones(dataSyndrome) == 1));
  assert_fetch_syn_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fetchFault != 3'd3) |-> (fetchSyndrome == 4'd0));
  assert_data_syn_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dataFault != 3'd4) |-> (dataSyndrome == 4'd0));

  assert_fault_zero_pa_R11: assert property (@(posedge clk) disable iff (!rstN)
    (fetchFault != 3'd0) |-> (fetchPa == '0));
  assert_dfault_zero_pa_R11: assert property (@(posedge clk) disable iff (!rstN)
    (dataFault != 3'd0) |-> (dataPa == '0));

endmodule

bind tlb_fault_unit tlbf_checker #(.EA_W(EA_W), .PAGE_BITS(PAGE_BITS)) u_chk (.*);

// File: tb/tlb_fault_unit_bench.sv
module tlb_fault_unit_bench;

  localparam int EA_W = 32;
  localparam int PAGE_BITS = 12;
  localparam int VPN_W = EA_W - PAGE_BITS;

  // Attribute bits: 0 seg, 1 page, 2 user, 3 write, 4 guarded, 5 changed
  localparam logic [5:0] ATTR_GOOD = 6'b101111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fetchValid = 1'b0, fetchXlateOn = 1'b0, fetchUser = 1'b0;
  logic [EA_W-1:0] fetchEa = '0;
  logic dataValid = 1'b0, dataXlateOn = 1'b0, dataUser = 1'b0;
  logic [EA_W-1:0] dataEa = '0;
  logic [1:0] dataType = 2'd0;
  logic rldValid = 1'b0, rldSide = 1'b0;
  logic [VPN_W-1:0] rldVpn = '0, rldPpn = '0;
  logic [5:0] rldAttr = '0;
  logic fetchRspValid, dataRspValid;
  logic [EA_W-1:0] fetchPa, dataPa;
  logic [2:0] fetchFault, dataFault;
  logic [3:0] fetchSyndrome, dataSyndrome;

  int nCmp = 0;
  int nFail = 0;
  int iLoads = 0;

  always #4 clk = ~clk;

  tlb_fault_unit u_tlb_fault_unit (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchEa(fetchEa), .fetchXlateOn(fetchXlateOn), .fetchUser(fetchUser),
    .dataValid(dataValid), .dataEa(dataEa), .dataType(dataType), .dataXlateOn(dataXlateOn), .dataUser(dataUser),
    .rldValid(rldValid), .rldSide(rldSide), .rldVpn(rldVpn), .rldPpn(rldPpn), .rldAttr(rldAttr),
    .fetchRspValid(fetchRspValid), .fetchPa(fetchPa), .fetchFault(fetchFault), .fetchSyndrome(fetchSyndrome),
    .dataRspValid(dataRspValid), .dataPa(dataPa), .dataFault(dataFault), .dataSyndrome(dataSyndrome)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reload(input logic side, input logic [VPN_W-1:0] vpn,
                        input logic [VPN_W-1:0] ppn, input logic [5:0] attr);
    @(negedge clk);
    rldValid = 1'b1; rldSide = side; rldVpn = vpn; rldPpn = ppn; rldAttr = attr;
    @(negedge clk);
    rldValid = 1'b0;
    if (!side) iLoads++;
  endtask

  task automatic fetch(input logic [EA_W-1:0] ea, input logic on, input logic user);
    @(negedge clk);
    fetchValid = 1'b1; fetchEa = ea; fetchXlateOn = on; fetchUser = user;
    @(negedge clk);
    fetchValid = 1'b0;
    chk("R1 fetch rspValid", 32'(fetchRspValid), 32'd1);
  endtask

  task automatic daccess(input logic [EA_W-1:0] ea, input logic [1:0] typ,
                         input logic on, input logic user);
    @(negedge clk);
    dataValid = 1'b1; dataEa = ea; dataType = typ; dataXlateOn = on; dataUser = user;
    @(negedge clk);
    dataValid = 1'b0;
    chk("R1 data rspValid", 32'(dataRspValid), 32'd1);
  endtask

  task automatic expF(input string tag, input logic [2:0] f, input logic [3:0] s, input logic [31:0] pa);
    chk({tag, " fetch fault"}, 32'(fetchFault), 32'(f));
    chk({tag, " fetch syndrome"}, 32'(fetchSyndrome), 32'(s));
    chk({tag, " fetch pa"}, fetchPa, pa);
  endtask

  task automatic expD(input string tag, input logic [2:0] f, input logic [3:0] s, input logic [31:0] pa);
    chk({tag, " data fault"}, 32'(dataFault), 32'(f));
    chk({tag, " data syndrome"}, 32'(dataSyndrome), 32'(s));
    chk({tag, " data pa"}, dataPa, pa);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 idle fetch rspValid", 32'(fetchRspValid), 32'd0);
    chk("R1 idle data rspValid", 32'(dataRspValid), 32'd0);
    expF("R1 idle", 3'd0, 4'd0, 32'd0);
    fetch(32'h0001_0123, 1'b1, 1'b0);
    expF("R12 R3 empty", 3'd1, 4'd0, 32'd0);
    daccess(32'h0002_0456, 2'd0, 1'b1, 1'b0);
    expD("R12 R4 empty", 3'd2, 4'd0, 32'd0);
    @(negedge clk);
    chk("R1 rspValid drops", 32'(fetchRspValid), 32'd0);
  endtask

  task automatic t_passthru;
    fetch(32'h1234_5678, 1'b0, 1'b1);
    expF("R2 fetch off", 3'd0, 4'd0, 32'h1234_5678);
    daccess(32'h9ABC_DEF0, 2'd1, 1'b0, 1'b1);
    expD("R2 data off", 3'd0, 4'd0, 32'h9ABC_DEF0);
  endtask

  task automatic t_hit;
    reload(1'b0, 20'h00010, 20'h0ABCD, ATTR_GOOD);
    fetch(32'h0001_0123, 1'b1, 1'b1);
    expF("R11 R10 fetch hit", 3'd0, 4'd0, 32'h0ABC_D123);
    daccess(32'h0001_0123, 2'd0, 1'b1, 1'b0);
    expD("R10 R4 side isolation", 3'd2, 4'd0, 32'd0);
    reload(1'b1, 20'h00020, 20'h00777, ATTR_GOOD);
    for (int t = 0; t < 4; t++) begin
      daccess(32'h0002_0ABC, 2'(t), 1'b1, 1'b1);
      expD("R11 data hit", 3'd0, 4'd0, 32'h0077_7ABC);
    end
    fetch(32'h0001_0FFF, 1'b0, 1'b0);
    expF("R2 off with entry", 3'd0, 4'd0, 32'h0001_0FFF);
  endtask

  task automatic t_invalid;
    reload(1'b0, 20'h00030, 20'h00300, 6'b101110);
    fetch(32'h0003_0000, 1'b1, 1'b0);
    expF("R5 seg invalid", 3'd3, 4'b0001, 32'd0);
    reload(1'b0, 20'h00031, 20'h00310, 6'b110001);
    fetch(32'h0003_1000, 1'b1, 1'b1);
    expF("R9 R5 invalid before prot", 3'd3, 4'b0001, 32'd0);
    reload(1'b1, 20'h00040, 20'h00400, 6'b101101);
    daccess(32'h0004_0010, 2'd2, 1'b1, 1'b0);
    expD("R5 data page invalid", 3'd4, 4'b0001, 32'd0);
  endtask

  task automatic t_prot;
    reload(1'b0, 20'h00050, 20'h00500, 6'b111011);
    fetch(32'h0005_0004, 1'b1, 1'b1);
    expF("R6 R9 user prot before guard", 3'd3, 4'b0010, 32'd0);
    fetch(32'h0005_0004, 1'b1, 1'b0);
    expF("R7 guarded fetch", 3'd3, 4'b0100, 32'd0);
    reload(1'b1, 20'h00060, 20'h00600, 6'b000111);
    daccess(32'h0006_0008, 2'd0, 1'b1, 1'b1);
    expD("R6 R8 load read-only ok", 3'd0, 4'd0, 32'h0060_0008);
    daccess(32'h0006_0008, 2'd1, 1'b1, 1'b0);
    expD("R6 R9 store prot before change", 3'd4, 4'b0010, 32'd0);
    daccess(32'h0006_0008, 2'd3, 1'b1, 1'b0);
    expD("R6 write cache op prot", 3'd4, 4'b0010, 32'd0);
    reload(1'b1, 20'h00061, 20'h00610, 6'b101011);
    daccess(32'h0006_1000, 2'd0, 1'b1, 1'b1);
    expD("R6 data user prot", 3'd4, 4'b0010, 32'd0);
  endtask

  task automatic t_change;
    reload(1'b1, 20'h00070, 20'h00700, 6'b011111);
    daccess(32'h0007_0020, 2'd0, 1'b1, 1'b1);
    expD("R7 R8 load ignores guard and change", 3'd0, 4'd0, 32'h0070_0020);
    daccess(32'h0007_0020, 2'd2, 1'b1, 1'b1);
    expD("R8 read cache op", 3'd0, 4'd0, 32'h0070_0020);
    daccess(32'h0007_0020, 2'd1, 1'b1, 1'b1);
    expD("R8 store change clear", 3'd4, 4'b1000, 32'd0);
    daccess(32'h0007_0020, 2'd3, 1'b1, 1'b1);
    expD("R8 write cache op change clear", 3'd4, 4'b1000, 32'd0);
  endtask

  task automatic t_roundrobin;
    while (iLoads < 8) reload(1'b0, 20'h00100 + 20'(iLoads), 20'h00800 + 20'(iLoads), ATTR_GOOD);
    fetch(32'h0001_0040, 1'b1, 1'b0);
    expF("R10 slot0 kept at full", 3'd0, 4'd0, 32'h0ABC_D040);
    reload(1'b0, 20'h00200, 20'h00900, ATTR_GOOD);
    fetch(32'h0001_0040, 1'b1, 1'b0);
    expF("R10 slot0 replaced", 3'd1, 4'd0, 32'd0);
    fetch(32'h0020_0040, 1'b1, 1'b0);
    expF("R10 new entry", 3'd0, 4'd0, 32'h0090_0040);
    fetch(32'h0003_0000, 1'b1, 1'b0);
    expF("R10 slot1 kept", 3'd3, 4'b0001, 32'd0);
    daccess(32'h0002_0ABC, 2'd0, 1'b1, 1'b0);
    expD("R10 data side untouched", 3'd0, 4'd0, 32'h0077_7ABC);
  endtask

  task automatic t_rereset;
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    fetch(32'h0020_0040, 1'b1, 1'b0);
    expF("R12 after reset fetch", 3'd1, 4'd0, 32'd0);
    daccess(32'h0002_0ABC, 2'd0, 1'b1, 1'b0);
    expD("R12 after reset data", 3'd2, 4'd0, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_passthru();
    t_hit();
    t_invalid();
    t_prot();
    t_change();
    t_roundrobin();
    t_rereset();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nCmp++;
    nFail++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nFail);
    $finish;
  end

endmodule